// File: doc/BRIEF.md
# Keyed Service Watchdog

This block is a free-running supervision counter. It asks for a system reset when software stops servicing it in time. Software services it by writing an ordered pair of key bytes to a single arm port. The byte 0x55 arms the sequence and a following 0xAA completes it. A completed sequence sends the count back to zero. Any other byte, or a completing byte that arrives while the sequence is not armed, raises a reset request at once.

The counter advances on single-cycle tick enables from one of two count sources: an internal RC tick or an oscillator tick. A three-bit select picks one of seven time-out lengths, and its zero code switches the watchdog off. In stop mode the count freezes. The exception is a low-power stop with the oscillator source selected and the oscillator kept running, in which case counting continues. The reset request is a registered pulse one cycle wide. The `SCALE` parameter shortens every period by the same power of two. It is meant for fast simulation only.

Top module: `keyed_watchdog`

## Requirements
- R1: A write of 0x55 followed by a write of 0xAA restarts the count from zero. The next expiry then needs the full selected number of count ticks.
- R2: A write of any byte other than 0x55 or 0xAA while the watchdog is enabled makes `reset_req` high in the next cycle.
- R3: A write of 0xAA when no 0x55 is pending is a wrong sequence and requests a reset. Writing 0x55 again while armed keeps the sequence armed.
- R4: The time-out is 2^(e−SCALE) count ticks after a restart. Here e is 14, 16, 18, 20, 22, 23 or 24 for `period_sel` codes 1 to 7. The tick that completes the period makes `reset_req` high in the next cycle.
- R5: A `period_sel` of 0 disables the watchdog. The count and key state stay cleared, writes are ignored and no request is raised.
- R6: When `src_osc` is 1 only `osc_tick` advances the count. When it is 0 only `rc_tick` does.
- R7: While `stop_mode` is 1 the count holds. It keeps counting only when `pseudo_stop`, `src_osc` and `osc_run_in_stop` are all 1.
- R8: `reset_req` is high for exactly one cycle. The request clears the count and the key state, and writes and ticks in the request cycle are ignored.
- R9: A completing 0xAA in the same cycle as the expiring tick counts as a service, and no request is raised.
- R10: Asserting `rst_n` low clears the count, the key state and `reset_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the arm port |
| wr_data | input | 8 | Byte written to the arm port |
| period_sel | input | 3 | Time-out code; 0 disables |
| src_osc | input | 1 | 1 selects the oscillator tick, 0 the RC tick |
| rc_tick | input | 1 | Count enable from the internal RC source |
| osc_tick | input | 1 | Count enable from the oscillator source |
| stop_mode | input | 1 | Stop mode is active |
| pseudo_stop | input | 1 | The stop is a low-power stop with the oscillator kept alive |
| osc_run_in_stop | input | 1 | The oscillator keeps running during stop |
| reset_req | output | 1 | One-cycle reset request |

## Verification
The bench measures all seven periods from a restart to the request. An off-by-one compare, or a wrong code-to-exponent mapping, shows up as a wrong cycle count. It lines up a completing 0xAA with the expiring tick to show that a service that loses to expiry gives a spurious reset. It also sends a bare 0xAA, a repeated 0x55 and a wrong byte in the request cycle itself, to catch a key machine that arms or resets wrongly or that gives two back-to-back pulses. Stop mode and source selection are driven with the wrong source ticking, so a counter that ignores either gate reaches time-out when it must not.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic {
    KEY_IDLE  = 1'b0,
    KEY_ARMED = 1'b1
  } key_state_e;

  localparam logic [7:0] KEY_OPEN  = 8'h55;
  localparam logic [7:0] KEY_CLOSE = 8'hAA;
  localparam int MAX_EXP = 24;
  localparam int MIN_EXP = 14;

  // Exponent for each period code: even steps up to code 5, then one step each.
  function automatic int unsigned period_exp(input logic [2:0] sel);
    int unsigned code;
    code = int'(sel);
    if (sel == 3'd0)      return MIN_EXP;
    else if (code <= 5)   return 12 + 2 * code;
    else                  return 17 + code;
  endfunction

  // Whether the count may advance given the low-power mode flags.
  function automatic logic run_allowed(input logic stop, input logic pstop,
                                       input logic src_osc, input logic osc_keep);
    return !stop || (pstop && src_osc && osc_keep);
  endfunction

endpackage

// File: rtl/wdt_tick_gate.sv
module wdt_tick_gate (
  input  logic src_osc,
  input  logic rc_tick,
  input  logic osc_tick,
  input  logic stop_mode,
  input  logic pseudo_stop,
  input  logic osc_run_in_stop,
  output logic step
);
  logic src_tick;
  logic run_ok;

  assign src_tick = src_osc ? osc_tick : rc_tick;
  assign run_ok   = wdt_pkg::run_allowed(stop_mode, pseudo_stop, src_osc, osc_run_in_stop);
  assign step     = src_tick && run_ok;
endmodule

// File: rtl/wdt_key_seq.sv
module wdt_key_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic       clear,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic       service,
  output logic       bad_key,
  output logic       armed
);
  import wdt_pkg::*;

  key_state_e state_q, state_d;
  logic is_open, is_close, take;

  assign armed    = (state_q == KEY_ARMED);
  assign take     = accept && wr_en;
  assign is_open  = (wr_data == KEY_OPEN);
  assign is_close = (wr_data == KEY_CLOSE);
  assign service  = take && is_close && armed;
  assign bad_key  = take && !is_open && !(is_close && armed);

  always_comb begin
    state_d = state_q;
    if (!accept || service || bad_key || clear) state_d = KEY_IDLE;
    else if (take && is_open)                  state_d = KEY_ARMED;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= KEY_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/wdt_period_cnt.sv
module wdt_period_cnt #(
  parameter int SCALE = 0,
  parameter int CNT_W = wdt_pkg::MAX_EXP - SCALE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enabled,
  input  logic             hold,
  input  logic             step,
  input  logic             restart,
  input  logic [2:0]       period_sel,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  logic [CNT_W:0]  last_val;
  logic [CNT_W:0]  one_w;
  int unsigned     shift;

  assign one_w = {{CNT_W{1'b0}}, 1'b1};

  always_comb begin
    shift    = wdt_pkg::period_exp(period_sel) - SCALE;
    last_val = (one_w << shift) - one_w;
  end

  assign expire = enabled && !hold && !restart && step && ({1'b0, count} >= last_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   count <= '0;
    else if (!enabled || hold || restart || expire) count <= '0;
    else if (step)                                count <= count + CNT_W'(1);
  end
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
  parameter int SCALE = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic [2:0] period_sel,
  input  logic       src_osc,
  input  logic       rc_tick,
  input  logic       osc_tick,
  input  logic       stop_mode,
  input  logic       pseudo_stop,
  input  logic       osc_run_in_stop,
  output logic       reset_req
);
  localparam int CNT_W = wdt_pkg::MAX_EXP - SCALE;

  logic             enabled, accept, step;
  logic             service, bad_key, armed, expire;
  logic [CNT_W-1:0] count;

  assign enabled = (period_sel != 3'd0);
  assign accept  = enabled && !reset_req;

  wdt_tick_gate u_gate (
    .src_osc(src_osc), .rc_tick(rc_tick), .osc_tick(osc_tick),
    .stop_mode(stop_mode), .pseudo_stop(pseudo_stop),
    .osc_run_in_stop(osc_run_in_stop), .step(step)
  );

  wdt_key_seq u_key (
    .clk(clk), .rst_n(rst_n), .accept(accept), .clear(expire),
    .wr_en(wr_en), .wr_data(wr_data),
    .service(service), .bad_key(bad_key), .armed(armed)
  );

  wdt_period_cnt #(.SCALE(SCALE), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .enabled(enabled), .hold(reset_req),
    .step(step), .restart(service || bad_key), .period_sel(period_sel),
    .count(count), .expire(expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reset_req <= 1'b0;
    else        reset_req <= bad_key || expire;
  end
endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reset_req,
  input logic             enabled,
  input logic             step,
  input logic             wr_en,
  input logic             service,
  input logic             bad_key,
  input logic             expire,
  input logic [CNT_W-1:0] count
);
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req); // R8
  AST_BAD_KEY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    bad_key |=> reset_req); // R2
  AST_SERVICE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    service |=> (count == '0) && !reset_req); // R1
  AST_EXPIRE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> reset_req); // R4
  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !enabled |=> !reset_req); // R5
  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (enabled && !step && !wr_en && !reset_req) |=> $stable(count)); // R7
endmodule

bind keyed_watchdog wdt_keyed_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reset_req(reset_req), .enabled(enabled),
  .step(step), .wr_en(wr_en), .service(service), .bad_key(bad_key),
  .expire(expire), .count(count)
);

// File: tb/sim_keyed_watchdog.sv
`timescale 1ns/1ps
module sim_keyed_watchdog;
  localparam int SC = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [2:0] period_sel = 3'd0;
  logic src_osc = 1'b0, rc_tick = 1'b0, osc_tick = 1'b0;
  logic stop_mode = 1'b0, pseudo_stop = 1'b0, osc_run_in_stop = 1'b0;
  logic reset_req;

  int tests = 0, fails = 0;
  bit done = 1'b0;
  bit cmp_on = 1'b0;

  // reference model state
  longint m_cnt = 0;
  bit m_armed = 1'b0, m_req = 1'b0;

  always #5 clk = ~clk;

  keyed_watchdog #(.SCALE(SC)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .period_sel(period_sel), .src_osc(src_osc), .rc_tick(rc_tick),
    .osc_tick(osc_tick), .stop_mode(stop_mode), .pseudo_stop(pseudo_stop),
    .osc_run_in_stop(osc_run_in_stop), .reset_req(reset_req)
  );

  function automatic longint ticks_for(input int code);
    int e;
    case (code)
      1: e = 14; 2: e = 16; 3: e = 18; 4: e = 20;
      5: e = 22; 6: e = 23; default: e = 24;
    endcase
    return longint'(1) << (e - SC);
  endfunction

  // behavioural reference, one update per rising edge
  always @(posedge clk or negedge rst_n) begin
    bit nreq, tick, run, bad, svc;
    if (!rst_n) begin
      m_cnt = 0; m_armed = 0; m_req = 0;
    end else begin
      nreq = 0;
      if (period_sel == 0) begin
        m_cnt = 0; m_armed = 0;
      end else if (!m_req) begin
        tick = src_osc ? osc_tick : rc_tick;
        run  = !stop_mode || (pseudo_stop && src_osc && osc_run_in_stop);
        bad = 0; svc = 0;
        if (wr_en) begin
          if (wr_data == 8'h55) m_armed = 1;
          else if (wr_data == 8'hAA && m_armed) svc = 1;
          else bad = 1;
        end
        if (bad) begin nreq = 1; m_cnt = 0; m_armed = 0; end
        else if (svc) begin m_cnt = 0; m_armed = 0; end
        else if (tick && run) begin
          if (m_cnt + 1 >= ticks_for(int'(period_sel))) begin
            nreq = 1; m_cnt = 0; m_armed = 0;
          end else m_cnt = m_cnt + 1;
        end
      end
      m_req = nreq;
    end
  end

  task automatic check(input string rq, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: reset_req actual %0b expected %0b at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic check_n(input string rq, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) if (cmp_on && rst_n) check("model R1-cycle", reset_req, m_req);

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reprogram(input logic [2:0] s);
    period_sel = 3'd0; idle(2);
    period_sel = s; wr(8'h55); wr(8'hAA);
  endtask

  int seen;

  initial begin
    idle(3);
    check("R10 reset state", reset_req, 1'b0);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    rc_tick = 1'b1;

    // R4: every period measured from a service
    for (int c = 1; c <= 7; c++) begin
      longint n;
      reprogram(3'(c));
      n = 0;
      while (reset_req !== 1'b1 && n < ticks_for(c) + 10) begin
        @(negedge clk); n++;
      end
      check_n($sformatf("R4 period code %0d", c), n, ticks_for(c));
      @(negedge clk);
      check("R8 pulse one cycle", reset_req, 1'b0);
    end

    // R1: regular service keeps it quiet
    reprogram(3'd1);
    seen = 0;
    for (int k = 0; k < 8; k++) begin
      idle(8); wr(8'h55); wr(8'hAA);
      if (reset_req) seen++;
    end
    check_n("R1 serviced, no request", seen, 0);

    // R2: wrong byte
    reprogram(3'd2);
    wr(8'h12);
    check("R2 wrong byte requests", reset_req, 1'b1);
    // R8: wrong byte in the request cycle is ignored
    wr(8'h34);
    check("R8 write ignored in request cycle", reset_req, 1'b0);

    // R3: bare close byte
    reprogram(3'd2);
    wr(8'hAA);
    check("R3 bare 0xAA requests", reset_req, 1'b1);
    // R3: repeated open byte stays armed
    reprogram(3'd2);
    wr(8'h55); wr(8'h55); wr(8'hAA);
    check("R3 0x55 twice then 0xAA is service", reset_req, 1'b0);

    // R9: service coincides with expiring tick
    reprogram(3'd1);
    idle(int'(ticks_for(1)) - 2);
    wr(8'h55); wr(8'hAA);
    check("R9 service wins over expiry", reset_req, 1'b0);
    idle(2);
    check("R9 no late request", reset_req, 1'b0);

    // R5: disabled ignores writes and ticks
    period_sel = 3'd0;
    wr(8'h77); wr(8'hAA);
    idle(100);
    check("R5 disabled stays silent", reset_req, 1'b0);

    // R6: oscillator source selected, only RC ticking
    reprogram(3'd1);
    src_osc = 1'b1; osc_tick = 1'b0;
    wr(8'h55); wr(8'hAA);
    seen = 0;
    for (int k = 0; k < 100; k++) begin @(negedge clk); if (reset_req) seen++; end
    check_n("R6 unselected source ignored", seen, 0);
    osc_tick = 1'b1;
    idle(int'(ticks_for(1)));
    check("R6 selected source expires", reset_req, 1'b1);

    // R7: stop halts, pseudo-stop with oscillator keeps running
    src_osc = 1'b0; reprogram(3'd1);
    stop_mode = 1'b1;
    seen = 0;
    for (int k = 0; k < 100; k++) begin @(negedge clk); if (reset_req) seen++; end
    check_n("R7 stop halts count", seen, 0);
    pseudo_stop = 1'b1; src_osc = 1'b1; osc_run_in_stop = 1'b0;
    idle(60);
    check("R7 stop without clock-enable halts", reset_req, 1'b0);
    osc_run_in_stop = 1'b1;
    seen = 0;
    for (int k = 0; k < 40; k++) begin @(negedge clk); if (reset_req) seen++; end
    check_n("R7 pseudo-stop keeps counting", seen, 2);
    stop_mode = 1'b0; pseudo_stop = 1'b0; osc_run_in_stop = 1'b0;

    // mixed stimulus, compared every cycle against the model
    for (int k = 0; k < 20000; k++) begin
      int r;
      r = int'($urandom_range(0, 99));
      rc_tick = $urandom_range(0, 1) == 1;
      osc_tick = $urandom_range(0, 2) != 0;
      src_osc = (r % 7) == 0 ? ~src_osc : src_osc;
      stop_mode = $urandom_range(0, 15) == 0;
      pseudo_stop = $urandom_range(0, 1) == 1;
      osc_run_in_stop = $urandom_range(0, 1) == 1;
      if (r < 2) period_sel = 3'($urandom_range(0, 2));
      wr_en = r >= 88;
      case ($urandom_range(0, 5))
        0, 1, 2: wr_data = 8'h55;
        3, 4:    wr_data = 8'hAA;
        default: wr_data = 8'($urandom_range(0, 255));
      endcase
      @(negedge clk);
    end
    wr_en = 1'b0;

    // R10: reset clears a pending request path
    period_sel = 3'd1; rst_n = 1'b0; idle(2);
    check("R10 reset clears request", reset_req, 1'b0);
    rst_n = 1'b1; idle(2);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1900000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: run hung, actual running expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule